// File: doc/BRIEF.md
# Transfer Acknowledge Generator with Refresh Hold-off

This block drives the active-low transfer acknowledge for a 16-bit asynchronous processor bus sitting in front of a dynamic-RAM controller. It takes the two active-low byte strobes, the direction line (high means read), and the controller's ready signal. Ready drops while a refresh holds off access. From these it decides when the processor may finish its bus cycle.

Reads are acknowledged when either byte strobe falls. Writes are acknowledged when the direction line falls. On a write the strobes arrive too late to meet acknowledge setup, so the direction line is used instead. The ready signal is captured in a flop on the system clock. While the captured value is low, the acknowledge is held off. Because of that register, the acknowledge stays blocked for one clock after a refresh finishes.

A read-modify-write therefore produces two separate acknowledge pulses: the strobes produce the first and the direction line the second. For faster processor grades, a parameter adds one flop after the gating, which gives one wait state.

Top module: `xfer_ack_gen`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after it, `xfer_ack_n` is 1 (deasserted), whatever the bus inputs and `mem_rdy` are.
- R2: With `rd_wr` = 1 and the captured ready = 1, `xfer_ack_n` is 0 when either or both of `strobe_hi_n` and `strobe_lo_n` are 0.
- R3: With `rd_wr` = 0 and the captured ready = 1, `xfer_ack_n` is 0 whatever the strobe levels.
- R4: With both strobes at 1 and `rd_wr` = 1, `xfer_ack_n` is 1 whatever `mem_rdy` is.
- R5: `mem_rdy` is sampled at each rising clock edge, and a sampled 0 forces `xfer_ack_n` to 1 until a later edge samples 1. After ready returns high, the acknowledge therefore stays deasserted until the next edge.
- R6: A read-modify-write gives two acknowledge pulses. The first comes from the strobes with `rd_wr` = 1. The acknowledge deasserts when the strobes return high. The second comes from `rd_wr` falling.
- R7: With `WAIT_EN` = 0, the acknowledge follows the gated term in the same cycle. With `WAIT_EN` = 1, `xfer_ack_n` equals the `WAIT_EN` = 0 value delayed by one clock edge, and that flop resets to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| strobe_hi_n | input | 1 | Upper byte strobe, active low |
| strobe_lo_n | input | 1 | Lower byte strobe, active low |
| rd_wr | input | 1 | Direction line: 1 = read, 0 = write |
| mem_rdy | input | 1 | Controller ready; 0 while a refresh holds off access |
| xfer_ack_n | output | 1 | Transfer acknowledge, active low |

## Verification
The assertions take for granted that the bus inputs and `mem_rdy` are stable around each rising clock edge. On that basis the level seen at an edge is the level the gating used just before it. The bench changes every input only at the falling edge. It compares both wait-state variants against a model of the ready register and the wait flop. Random stimulus mixes idle, read, write and refresh patterns, and directed sequences cover read-modify-write and refresh collisions.

// File: rtl/xfer_ack_pkg.sv
package xfer_ack_pkg;
  localparam logic ACK_ON  = 1'b0;
  localparam logic ACK_OFF = 1'b1;

  // Gated bus term: low as soon as any of its inputs is low.
  function automatic logic bus_term(input logic hi_n, input logic lo_n,
                                    input logic rw);
    return hi_n & lo_n & rw;
  endfunction
endpackage

// File: rtl/ack_strobe_gate.sv
module ack_strobe_gate
  import xfer_ack_pkg::*;
(
  input  logic strobe_hi_n,
  input  logic strobe_lo_n,
  input  logic rd_wr,
  output logic term_n
);
  // Reads finish on the strobes, writes on the direction line.
  always_comb term_n = bus_term(strobe_hi_n, strobe_lo_n, rd_wr);
endmodule

// File: rtl/ack_ready_reg.sv
module ack_ready_reg
  import xfer_ack_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mem_rdy,
  output logic rdy_q
);
  // Reset to "not ready" so the acknowledge starts deasserted.
  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= mem_rdy;
  end
endmodule

// File: rtl/ack_wait_stage.sv
module ack_wait_stage
  import xfer_ack_pkg::*;
#(
  parameter bit WAIT_EN = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_in_n,
  output logic ack_out_n
);
  generate
    if (WAIT_EN) begin : g_wait
      logic ws_q;
      always_ff @(posedge clk) begin
        if (rst) ws_q <= ACK_OFF;
        else     ws_q <= ack_in_n;
      end
      assign ack_out_n = ws_q;
    end else begin : g_direct
      assign ack_out_n = ack_in_n;
    end
  endgenerate
endmodule

// File: rtl/xfer_ack_gen.sv
module xfer_ack_gen
  import xfer_ack_pkg::*;
#(
  parameter bit WAIT_EN = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_hi_n,
  input  logic strobe_lo_n,
  input  logic rd_wr,
  input  logic mem_rdy,
  output logic xfer_ack_n
);
  logic term_n;
  logic rdy_q;
  logic raw_ack_n;

  ack_strobe_gate u_gate (
    .strobe_hi_n (strobe_hi_n),
    .strobe_lo_n (strobe_lo_n),
    .rd_wr       (rd_wr),
    .term_n      (term_n)
  );

  ack_ready_reg u_rdy (
    .clk     (clk),
    .rst     (rst),
    .mem_rdy (mem_rdy),
    .rdy_q   (rdy_q)
  );

  // Captured ready low forces the acknowledge off.
  always_comb raw_ack_n = term_n | ~rdy_q;

  ack_wait_stage #(.WAIT_EN(WAIT_EN)) u_wait (
    .clk       (clk),
    .rst       (rst),
    .ack_in_n  (raw_ack_n),
    .ack_out_n (xfer_ack_n)
  );
endmodule

// File: rtl/xfer_ack_gen_chk.sv
module xfer_ack_gen_chk #(
  parameter bit WAIT_EN = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic strobe_hi_n,
  input logic strobe_lo_n,
  input logic rd_wr,
  input logic mem_rdy,
  input logic xfer_ack_n
);
  logic idle;
  logic rd_hit;
  assign idle   = strobe_hi_n & strobe_lo_n & rd_wr;
  assign rd_hit = rd_wr & ~(strobe_hi_n & strobe_lo_n);

  // R1
  reset_off_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> xfer_ack_n);

  generate
    if (WAIT_EN) begin : g_ws
      // R4
      idle_off_chk: assert property (@(posedge clk) disable iff (rst)
        idle |=> xfer_ack_n);
      // R5
      refresh_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(mem_rdy) |=> xfer_ack_n);
      // R3 R7
      write_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_wr && $past(mem_rdy) && !$past(rst)) |=> !xfer_ack_n);
      // R2 R7
      read_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && $past(mem_rdy) && !$past(rst)) |=> !xfer_ack_n);
    end else begin : g_nows
      // R4
      idle_off_chk: assert property (@(posedge clk) disable iff (rst)
        idle |-> xfer_ack_n);
      // R5
      refresh_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(mem_rdy) |-> xfer_ack_n);
      // R3
      write_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_wr && $past(mem_rdy) && !$past(rst)) |-> !xfer_ack_n);
      // R2
      read_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && $past(mem_rdy) && !$past(rst)) |-> !xfer_ack_n);
    end
  endgenerate
endmodule

bind xfer_ack_gen xfer_ack_gen_chk #(.WAIT_EN(WAIT_EN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .strobe_hi_n (strobe_hi_n),
  .strobe_lo_n (strobe_lo_n),
  .rd_wr       (rd_wr),
  .mem_rdy     (mem_rdy),
  .xfer_ack_n  (xfer_ack_n)
);

// File: tb/test_xfer_ack_gen.sv
module test_xfer_ack_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hi_n = 1'b1, lo_n = 1'b1, rw = 1'b1, rdy = 1'b0;
  logic ack0_n, ack1_n;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  always #4 clk = ~clk;

  xfer_ack_gen #(.WAIT_EN(1'b0)) i_xfer_ack_gen (
    .clk(clk), .rst(rst), .strobe_hi_n(hi_n), .strobe_lo_n(lo_n),
    .rd_wr(rw), .mem_rdy(rdy), .xfer_ack_n(ack0_n));

  xfer_ack_gen #(.WAIT_EN(1'b1)) i_xfer_ack_gen_ws (
    .clk(clk), .rst(rst), .strobe_hi_n(hi_n), .strobe_lo_n(lo_n),
    .rd_wr(rw), .mem_rdy(rdy), .xfer_ack_n(ack1_n));

  // Model of the captured ready and the wait flop.
  logic m_rdy = 1'b0;
  logic m_ws  = 1'b1;

  function automatic logic exp_raw(logic h, logic l, logic r, logic q);
    return (h & l & r) | ~q;
  endfunction

  always @(posedge clk) begin
    m_ws  <= rst ? 1'b1 : exp_raw(hi_n, lo_n, rw, m_rdy);
    m_rdy <= rst ? 1'b0 : rdy;
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // Drive at falling edge, check shortly before the next rising edge.
  task automatic step(logic h, logic l, logic r, logic rd, string tag);
    @(negedge clk);
    hi_n = h; lo_n = l; rw = r; rdy = rd;
    #3;
    chk(tag, ack0_n, exp_raw(hi_n, lo_n, rw, m_rdy));
    chk({tag, " R7"}, ack1_n, m_ws);
  endtask

  function automatic string classify();
    if (!m_rdy)                return "R5";
    if (hi_n && lo_n && rw)    return "R4";
    if (!rw)                   return "R3";
    return "R2";
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4417));
    // R1: reset with bus active and ready high
    rst = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b1, "R1");
    step(1'b0, 1'b1, 1'b0, 1'b1, "R1");
    @(negedge clk); rst = 1'b0; #3;
    chk("R1", ack0_n, 1'b1);
    chk("R1 R7", ack1_n, 1'b1);

    // R2 reads: each strobe alone and both
    step(1'b1, 1'b1, 1'b1, 1'b1, "R4");
    step(1'b0, 1'b1, 1'b1, 1'b1, "R2");
    step(1'b1, 1'b0, 1'b1, 1'b1, "R2");
    step(1'b0, 1'b0, 1'b1, 1'b1, "R2");
    step(1'b1, 1'b1, 1'b1, 1'b1, "R4");
    // R3 write before strobes
    step(1'b1, 1'b1, 1'b0, 1'b1, "R3");
    step(1'b0, 1'b0, 1'b0, 1'b1, "R3");
    // R4 idle with ready low
    step(1'b1, 1'b1, 1'b1, 1'b0, "R4");
    step(1'b1, 1'b1, 1'b1, 1'b0, "R4");

    // R6 read-modify-write: two separate pulses
    step(1'b1, 1'b1, 1'b1, 1'b1, "R6");
    step(1'b1, 1'b1, 1'b1, 1'b1, "R6");
    step(1'b0, 1'b0, 1'b1, 1'b1, "R6");
    step(1'b0, 1'b0, 1'b1, 1'b1, "R6");
    step(1'b1, 1'b1, 1'b1, 1'b1, "R6");
    step(1'b1, 1'b1, 1'b0, 1'b1, "R6");
    step(1'b0, 1'b0, 1'b0, 1'b1, "R6");
    step(1'b1, 1'b1, 1'b1, 1'b1, "R6");

    // R5 refresh collision: write pending while ready low
    step(1'b1, 1'b1, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b0, 1'b0, 1'b1, "R5");
    @(negedge clk); #3;
    chk("R5 release", ack0_n, 1'b0);
    chk("R5 R7", ack1_n, m_ws);
    step(1'b0, 1'b1, 1'b1, 1'b0, "R5");

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic h, l, r, d;
      int   kind;
      kind = int'($urandom_range(0, 3));
      h = 1'b1; l = 1'b1; r = 1'b1;
      case (kind)
        1: begin h = 1'($urandom); l = 1'($urandom); end
        2: begin r = 1'b0; h = 1'($urandom); l = h; end
        3: begin h = 1'($urandom); l = 1'($urandom); r = 1'($urandom); end
        default: ;
      endcase
      d = ($urandom_range(0, 4) != 0);
      @(negedge clk);
      hi_n = h; lo_n = l; rw = r; rdy = d;
      if ($urandom_range(0, 199) == 0) rst = 1'b1;
      else                            rst = 1'b0;
      #3;
      chk(classify(), ack0_n, exp_raw(hi_n, lo_n, rw, m_rdy));
      chk("R7", ack1_n, m_ws);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule